// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block models the command state machine of a parallel NOR flash device. It observes bus write cycles (address plus data byte, qualified by a write strobe) and recognises the unlock-prefixed command sequences for byte program, whole-array erase, per-sector erase with queued sectors, erase suspend and resume, identifier readout and reset. Reads return one of three things: a byte of a small internal storage array, an identifier code, or a status byte while an embedded operation is running.

Program and erase run as embedded operations whose length is set by a cycle counter. The array is organised as `NUM_SECT` sectors of `SECT_BYTES` bytes. The sector number is taken from the top address bits and the byte offset from the low address bits. Command keys are matched on address bits 14:0. Neither the write port nor the read port has back-pressure. Every write strobe is taken in the cycle it is high. Every read strobe produces a registered result, flagged by `rd_valid`, one cycle later. A writer therefore must not issue a strobe it cannot afford to have consumed.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset the machine is in array-read mode, `busy` is 0, `rd_valid` is 0 and every array byte reads FFh.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h followed by one write (address, data) program that byte to old AND data. `busy` is 1 from the cycle after that final write for exactly `PROG_CYC` cycles.
- R3: While a program runs, a status read returns bit7 = inverse of bit7 of the programmed data, bit5 = 0 and bit3 = 0. Bit6 changes between successive status reads.
- R4: A program whose data has a 1 where the stored byte has a 0 leaves the byte unchanged. After `PROG_CYC` cycles it reports bit5 = 1 and keeps `busy` at 1 until an F0h write, which returns the machine to read mode.
- R5: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h erase the whole array to FFh, with `busy` high while the erase runs.
- R6: The same five-write prefix followed by 30h at any address in a sector opens a sector-erase window of `WIN_CYC` cycles. Further 30h writes in the window queue their sectors and restart the window. Status reads return bit3 = 0 during the window and bit3 = 1 once erasing starts, with bit7 = 0 throughout. Only queued sectors become FFh.
- R7: B0h during a sector erase suspends it. `busy` drops in the next cycle, the array reads normally and the erase timer holds. A 30h write then resumes the erase, which completes. B0h or 30h written in read mode changes nothing.
- R8: The writes AAh@5555h, 55h@2AAAh, 90h@5555h enter identifier mode. In this mode a read at low byte offset 00h returns 01h, offset 01h returns `DEV_ID` (default ABh) and any other offset returns 00h. Both codes have odd parity. An F0h write exits to read mode.
- R9: A write that does not match the expected next step of a sequence aborts it and returns the machine to read mode, so no operation starts.
- R10: `rd_valid` is 1 exactly in the cycle after a cycle with `rd_en` high, and `rd_data` holds the result in that cycle.
- R11: Writes made while a program or erase runs are ignored; they neither start nor advance a command sequence.
- R12: The writes AAh@5555h, 55h@2AAAh, F0h@5555h also return the machine to read mode, including from identifier mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| wr_en | input | 1 | Write strobe, one bus write per high cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data / command byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result, valid with rd_valid |
| rd_valid | output | 1 | High the cycle after rd_en |
| busy | output | 1 | 1 while an embedded program or erase is running or failed |

## Verification
The embedded assertions check properties on every cycle. A failed program stays failed until reset. An expired erase window moves on to erasing. A broken unlock step returns the machine to read mode. The erase timer is frozen while suspended. A rise of `busy` always follows a write. Identifier reads carry odd parity. `rd_valid` tracks `rd_en`. A sector erase actually clears its bytes. Only the bench scenarios can show the following: the AND semantics of programming, the exact busy length, toggling status between reads, queued sectors being the only ones erased, resume completing the work, and writes during busy or in read mode having no effect on the array.

// File: rtl/fce_pkg.sv
package fce_pkg;

  typedef enum logic [3:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_PGM_ARM,
    ST_ERS_A,
    ST_ERS_B,
    ST_ERS_C,
    ST_IDENT,
    ST_PGM_RUN,
    ST_PGM_FAIL,
    ST_ERS_WIN,
    ST_ERS_RUN,
    ST_CHIP_RUN,
    ST_ERS_SUSP
  } fce_state_e;

  localparam logic [14:0] KEY_ADDR_A = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;

  localparam logic [7:0] CMD_UNL1  = 8'hAA;
  localparam logic [7:0] CMD_UNL2  = 8'h55;
  localparam logic [7:0] CMD_PGM   = 8'hA0;
  localparam logic [7:0] CMD_ERS   = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] CMD_RST   = 8'hF0;

  function automatic logic op_busy(fce_state_e s);
    return (s == ST_PGM_RUN) || (s == ST_PGM_FAIL) || (s == ST_ERS_WIN) ||
           (s == ST_ERS_RUN) || (s == ST_CHIP_RUN);
  endfunction

endpackage

// File: rtl/fce_timer.sv
module fce_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          expire
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire = run && (cnt_q == CW'(1));

  // R7
  suspend_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/fce_store.sv
module fce_store #(
  parameter int ADDR_W     = 16,
  parameter int NUM_SECT   = 4,
  parameter int SECT_BYTES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [7:0]          rd_byte,
  input  logic [ADDR_W-1:0]   lk_addr,
  output logic [7:0]          lk_byte,
  input  logic                pgm_en,
  input  logic [ADDR_W-1:0]   pgm_addr,
  input  logic [7:0]          pgm_data,
  input  logic                ers_en,
  input  logic [NUM_SECT-1:0] ers_mask
);

  localparam int SW    = $clog2(NUM_SECT);
  localparam int OW    = $clog2(SECT_BYTES);
  localparam int IW    = SW + OW;
  localparam int DEPTH = NUM_SECT * SECT_BYTES;

  logic [IW-1:0] rd_idx, lk_idx, pgm_idx;
  logic [7:0]    bytes_q [DEPTH];

  assign rd_idx  = {rd_addr[ADDR_W-1 -: SW],  rd_addr[OW-1:0]};
  assign lk_idx  = {lk_addr[ADDR_W-1 -: SW],  lk_addr[OW-1:0]};
  assign pgm_idx = {pgm_addr[ADDR_W-1 -: SW], pgm_addr[OW-1:0]};

  logic unused_addr_bits;
  assign unused_addr_bits = ^{rd_addr[ADDR_W-SW-1:OW], lk_addr[ADDR_W-SW-1:OW],
                              pgm_addr[ADDR_W-SW-1:OW]};

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam int SEC = i / SECT_BYTES;
    logic [7:0] cell_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                        cell_q <= 8'hFF;
      else if (ers_en && ers_mask[SEC])  cell_q <= 8'hFF;
      else if (pgm_en && pgm_idx == IW'(i)) cell_q <= cell_q & pgm_data;
    end
    assign bytes_q[i] = cell_q;
  end

  assign rd_byte = bytes_q[rd_idx];
  assign lk_byte = bytes_q[lk_idx];

  // R5
  ers_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_en && ers_mask[0]) |=> (bytes_q[0] == 8'hFF));

endmodule

// File: rtl/fce_decoder.sv
module fce_decoder
  import fce_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_SECT  = 4,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 40,
  parameter int WIN_CYC   = 10,
  parameter int CW        = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [7:0]          lk_byte,
  input  logic                tmr_expire,
  output fce_state_e          state_q,
  output logic                tmr_load,
  output logic [CW-1:0]       tmr_val,
  output logic                tmr_run,
  output logic                pgm_en,
  output logic [ADDR_W-1:0]   pgm_addr,
  output logic [7:0]          pgm_data,
  output logic                ers_en,
  output logic [NUM_SECT-1:0] ers_mask
);

  localparam int SW = $clog2(NUM_SECT);

  fce_state_e          nxt;
  logic                pgm_bad_q, latch_pgm, mask_add, mask_clr;
  logic [NUM_SECT-1:0] mask_q;
  logic                key_a, key_b;
  logic [SW-1:0]       sect;

  assign key_a = (wr_addr[14:0] == KEY_ADDR_A);
  assign key_b = (wr_addr[14:0] == KEY_ADDR_B);
  assign sect  = wr_addr[ADDR_W-1 -: SW];

  always_comb begin
    nxt       = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    pgm_en    = 1'b0;
    ers_en    = 1'b0;
    latch_pgm = 1'b0;
    mask_add  = 1'b0;
    mask_clr  = 1'b0;
    case (state_q)
      ST_READ, ST_IDENT: if (wr_en)
        nxt = (key_a && wr_data == CMD_UNL1) ? ST_UNL1 : ST_READ;
      ST_UNL1: if (wr_en)
        nxt = (key_b && wr_data == CMD_UNL2) ? ST_UNL2 : ST_READ;
      ST_UNL2: if (wr_en) begin
        nxt = ST_READ;
        if (key_a) begin
          case (wr_data)
            CMD_PGM:   nxt = ST_PGM_ARM;
            CMD_ERS:   nxt = ST_ERS_A;
            CMD_IDENT: nxt = ST_IDENT;
            default:   nxt = ST_READ;
          endcase
        end
      end
      ST_PGM_ARM: if (wr_en) begin
        nxt       = ST_PGM_RUN;
        latch_pgm = 1'b1;
        tmr_load  = 1'b1;
        tmr_val   = CW'(PROG_CYC);
      end
      ST_ERS_A: if (wr_en)
        nxt = (key_a && wr_data == CMD_UNL1) ? ST_ERS_B : ST_READ;
      ST_ERS_B: if (wr_en)
        nxt = (key_b && wr_data == CMD_UNL2) ? ST_ERS_C : ST_READ;
      ST_ERS_C: if (wr_en) begin
        if (key_a && wr_data == CMD_CHIP) begin
          nxt      = ST_CHIP_RUN;
          tmr_load = 1'b1;
          tmr_val  = CW'(ERASE_CYC);
        end else if (wr_data == CMD_SECT) begin
          nxt      = ST_ERS_WIN;
          mask_add = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CW'(WIN_CYC);
        end else begin
          nxt = ST_READ;
        end
      end
      ST_ERS_WIN: begin
        if (wr_en && wr_data == CMD_SECT) begin
          mask_add = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CW'(WIN_CYC);
        end else if (wr_en && wr_data == CMD_SUSP) begin
          nxt      = ST_ERS_SUSP;
          tmr_load = 1'b1;
          tmr_val  = CW'(ERASE_CYC);
        end else if (tmr_expire) begin
          nxt      = ST_ERS_RUN;
          tmr_load = 1'b1;
          tmr_val  = CW'(ERASE_CYC);
        end
      end
      ST_ERS_RUN: begin
        if (wr_en && wr_data == CMD_SUSP) begin
          nxt = ST_ERS_SUSP;
        end else if (tmr_expire) begin
          nxt      = ST_READ;
          ers_en   = 1'b1;
          mask_clr = 1'b1;
        end
      end
      ST_ERS_SUSP: if (wr_en && wr_data == CMD_SECT) nxt = ST_ERS_RUN;
      ST_CHIP_RUN: if (tmr_expire) begin
        nxt    = ST_READ;
        ers_en = 1'b1;
      end
      ST_PGM_RUN: if (tmr_expire) begin
        if (pgm_bad_q) begin
          nxt = ST_PGM_FAIL;
        end else begin
          nxt    = ST_READ;
          pgm_en = 1'b1;
        end
      end
      ST_PGM_FAIL: if (wr_en && wr_data == CMD_RST) nxt = ST_READ;
      default: nxt = ST_READ;
    endcase
  end

  assign tmr_run  = (state_q == ST_PGM_RUN) || (state_q == ST_ERS_WIN) ||
                    (state_q == ST_ERS_RUN) || (state_q == ST_CHIP_RUN);
  assign ers_mask = (state_q == ST_CHIP_RUN) ? '1 : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_READ;
      pgm_addr  <= '0;
      pgm_data  <= '0;
      pgm_bad_q <= 1'b0;
      mask_q    <= '0;
    end else begin
      state_q <= nxt;
      if (latch_pgm) begin
        pgm_addr  <= wr_addr;
        pgm_data  <= wr_data;
        pgm_bad_q <= |(wr_data & ~lk_byte);
      end
      if (mask_clr)      mask_q       <= '0;
      else if (mask_add) mask_q[sect] <= 1'b1;
    end
  end

  // R4
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PGM_FAIL && !(wr_en && wr_data == CMD_RST)) |=> (state_q == ST_PGM_FAIL));

  // R6
  win_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERS_WIN && tmr_expire && !wr_en) |=> (state_q == ST_ERS_RUN));

  // R9
  seq_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UNL1 && wr_en && wr_data != CMD_UNL2) |=> (state_q == ST_READ));

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import fce_pkg::*;
#(
  parameter int         ADDR_W     = 16,
  parameter int         NUM_SECT   = 4,
  parameter int         SECT_BYTES = 8,
  parameter int         PROG_CYC   = 16,
  parameter int         ERASE_CYC  = 40,
  parameter int         WIN_CYC    = 10,
  parameter logic [7:0] MFR_ID     = 8'h01,
  parameter logic [7:0] DEV_ID     = 8'hAB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              busy
);

  localparam int TMAX_A = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int TMAX   = (TMAX_A > WIN_CYC) ? TMAX_A : WIN_CYC;
  localparam int CW     = $clog2(TMAX + 1);

  fce_state_e          state;
  logic                tmr_load, tmr_run, tmr_expire;
  logic [CW-1:0]       tmr_val;
  logic                pgm_en, ers_en;
  logic [ADDR_W-1:0]   pgm_addr;
  logic [7:0]          pgm_data, rd_byte, lk_byte;
  logic [NUM_SECT-1:0] ers_mask;
  logic                tog_q;
  logic [7:0]          status, ident;

  fce_decoder #(
    .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC), .CW(CW)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lk_byte(lk_byte), .tmr_expire(tmr_expire), .state_q(state),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_run(tmr_run),
    .pgm_en(pgm_en), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .ers_en(ers_en), .ers_mask(ers_mask)
  );

  fce_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .run(tmr_run), .expire(tmr_expire)
  );

  fce_store #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .SECT_BYTES(SECT_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_byte(rd_byte),
    .lk_addr(wr_addr), .lk_byte(lk_byte), .pgm_en(pgm_en), .pgm_addr(pgm_addr),
    .pgm_data(pgm_data), .ers_en(ers_en), .ers_mask(ers_mask)
  );

  assign busy = op_busy(state);

  always_comb begin
    status    = 8'h00;
    status[7] = ((state == ST_PGM_RUN) || (state == ST_PGM_FAIL)) ? ~pgm_data[7] : 1'b0;
    status[6] = tog_q;
    status[5] = (state == ST_PGM_FAIL);
    status[3] = (state == ST_ERS_RUN) || (state == ST_CHIP_RUN);
  end

  always_comb begin
    case (rd_addr[7:0])
      8'h00:   ident = MFR_ID;
      8'h01:   ident = DEV_ID;
      default: ident = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= 8'h00;
      rd_valid <= 1'b0;
      tog_q    <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (!busy) tog_q <= 1'b0;
      if (rd_en) begin
        if (busy) begin
          rd_data <= status;
          tog_q   <= ~tog_q;
        end else if (state == ST_IDENT) begin
          rd_data <= ident;
        end else begin
          rd_data <= rd_byte;
        end
      end
    end
  end

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  // R8
  id_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy && state == ST_IDENT && rd_addr[7:1] == 7'd0) |=> (^rd_data));

  // R10
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

endmodule

// File: tb/test_flash_cmd_engine.sv
module test_flash_cmd_engine;

  localparam int PROG_CYC  = 16;
  localparam int ERASE_CYC = 40;
  localparam int WIN_CYC   = 10;
  localparam int NV        = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  flash_cmd_engine #(
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC)
  ) i_flash_cmd_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // op: 0 write, 1 read-and-compare, 2 wait until not busy; fields {op, req, addr, data, exp}
  localparam logic [37:0] VEC [NV] = '{
    {2'd1, 4'd1,  16'h0000, 8'h00, 8'hFF},  // R1 erased after reset
    {2'd0, 4'd2,  16'h5555, 8'hAA, 8'h00},  // R2 program 0003 <- 5A
    {2'd0, 4'd2,  16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd2,  16'h5555, 8'hA0, 8'h00},
    {2'd0, 4'd2,  16'h0003, 8'h5A, 8'h00},
    {2'd2, 4'd2,  16'h0000, 8'h00, 8'h00},
    {2'd1, 4'd2,  16'h0003, 8'h00, 8'h5A},
    {2'd0, 4'd2,  16'h5555, 8'hAA, 8'h00},  // R2 clear one more bit
    {2'd0, 4'd2,  16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd2,  16'h5555, 8'hA0, 8'h00},
    {2'd0, 4'd2,  16'h0003, 8'h52, 8'h00},
    {2'd2, 4'd2,  16'h0000, 8'h00, 8'h00},
    {2'd1, 4'd2,  16'h0003, 8'h00, 8'h52},
    {2'd0, 4'd8,  16'h5555, 8'hAA, 8'h00},  // R8 identifier mode
    {2'd0, 4'd8,  16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd8,  16'h5555, 8'h90, 8'h00},
    {2'd1, 4'd8,  16'h0000, 8'h00, 8'h01},
    {2'd1, 4'd8,  16'h0001, 8'h00, 8'hAB},
    {2'd0, 4'd8,  16'h0000, 8'hF0, 8'h00},
    {2'd1, 4'd8,  16'h0003, 8'h00, 8'h52},
    {2'd0, 4'd9,  16'h5555, 8'hAA, 8'h00},  // R9 wrong second step
    {2'd0, 4'd9,  16'h2AAA, 8'h00, 8'h00},
    {2'd0, 4'd9,  16'h5555, 8'hA0, 8'h00},
    {2'd0, 4'd9,  16'h4001, 8'h00, 8'h00},
    {2'd2, 4'd9,  16'h0000, 8'h00, 8'h00},
    {2'd1, 4'd9,  16'h4001, 8'h00, 8'hFF},
    {2'd0, 4'd7,  16'h0003, 8'h30, 8'h00},  // R7 stray resume / suspend
    {2'd0, 4'd7,  16'h0003, 8'hB0, 8'h00},
    {2'd1, 4'd7,  16'h0003, 8'h00, 8'h52},
    {2'd0, 4'd6,  16'h5555, 8'hAA, 8'h00},  // R6 setup 4002 <- 11
    {2'd0, 4'd6,  16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd6,  16'h5555, 8'hA0, 8'h00},
    {2'd0, 4'd6,  16'h4002, 8'h11, 8'h00},
    {2'd2, 4'd6,  16'h0000, 8'h00, 8'h00},
    {2'd0, 4'd6,  16'h5555, 8'hAA, 8'h00},  // R6 setup 8004 <- 22
    {2'd0, 4'd6,  16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd6,  16'h5555, 8'hA0, 8'h00},
    {2'd0, 4'd6,  16'h8004, 8'h22, 8'h00},
    {2'd2, 4'd6,  16'h0000, 8'h00, 8'h00},
    {2'd0, 4'd6,  16'h5555, 8'hAA, 8'h00},  // R6 setup C005 <- 33
    {2'd0, 4'd6,  16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd6,  16'h5555, 8'hA0, 8'h00},
    {2'd0, 4'd6,  16'hC005, 8'h33, 8'h00},
    {2'd2, 4'd6,  16'h0000, 8'h00, 8'h00},
    {2'd0, 4'd6,  16'h5555, 8'hAA, 8'h00},  // R6 erase sectors 1 and 2
    {2'd0, 4'd6,  16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd6,  16'h5555, 8'h80, 8'h00},
    {2'd0, 4'd6,  16'h5555, 8'hAA, 8'h00},
    {2'd0, 4'd6,  16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd6,  16'h4000, 8'h30, 8'h00},
    {2'd0, 4'd6,  16'h8000, 8'h30, 8'h00},
    {2'd2, 4'd6,  16'h0000, 8'h00, 8'h00},
    {2'd1, 4'd6,  16'h4002, 8'h00, 8'hFF},
    {2'd1, 4'd6,  16'h8004, 8'h00, 8'hFF},
    {2'd1, 4'd6,  16'hC005, 8'h00, 8'h33},
    {2'd0, 4'd5,  16'h5555, 8'hAA, 8'h00},  // R5 whole-array erase
    {2'd0, 4'd5,  16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd5,  16'h5555, 8'h80, 8'h00},
    {2'd0, 4'd5,  16'h5555, 8'hAA, 8'h00},
    {2'd0, 4'd5,  16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd5,  16'h5555, 8'h10, 8'h00},
    {2'd2, 4'd5,  16'h0000, 8'h00, 8'h00},
    {2'd1, 4'd5,  16'h0003, 8'h00, 8'hFF},
    {2'd1, 4'd5,  16'hC005, 8'h00, 8'hFF}
  };

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic unlock_pgm(input logic [15:0] a, input logic [7:0] d);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(a, d);
  endtask

  initial begin
    logic [7:0] s1, s2, v;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy after reset", {7'd0, busy}, 8'h00);
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", {7'd0, rd_valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [3:0] rq;
      op = VEC[i][37:36];
      rq = VEC[i][35:32];
      if (op == 2'd0) wr(VEC[i][31:16], VEC[i][15:8]);
      else if (op == 2'd2) wait_idle();
      else begin
        rd(VEC[i][31:16], v);
        chk(v == VEC[i][7:0], $sformatf("R%0d vector %0d", rq, i), v, VEC[i][7:0]);
      end
    end

    // R10 read strobe timing
    @(negedge clk);
    chk(rd_valid == 1'b0, "R10 rd_valid idle", {7'd0, rd_valid}, 8'h00);
    rd(16'h0000, v);
    chk(rd_valid == 1'b1, "R10 rd_valid after strobe", {7'd0, rd_valid}, 8'h01);

    // R2 exact busy length
    unlock_pgm(16'h0006, 8'h00);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == PROG_CYC, "R2 busy cycles", 8'(n), 8'(PROG_CYC));

    // R3 status during program, R11 writes ignored while busy
    unlock_pgm(16'h0007, 8'h7F);
    rd(16'h0000, s1);
    rd(16'h0000, s2);
    chk(s1[7] == 1'b1 && s1[5] == 1'b0 && s1[3] == 1'b0, "R3 status bits", s1, 8'h80);
    chk(s1[6] != s2[6], "R3 toggle bit", s2, {s1[7], ~s1[6], s1[5:0]});
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0);
    wait_idle();
    wr(16'h0007, 8'h00);
    wait_idle();
    rd(16'h0007, v);
    chk(v == 8'h7F, "R11 writes during busy ignored", v, 8'h7F);

    // R4 program that would set a bit
    unlock_pgm(16'h0007, 8'hFF);
    repeat (PROG_CYC + 4) @(negedge clk);
    chk(busy == 1'b1, "R4 stays busy", {7'd0, busy}, 8'h01);
    rd(16'h0000, s1);
    chk(s1[5] == 1'b1, "R4 timeout bit", s1, 8'h20);
    wr(16'h0000, 8'hF0);
    chk(busy == 1'b0, "R4 reset clears busy", {7'd0, busy}, 8'h00);
    rd(16'h0007, v);
    chk(v == 8'h7F, "R4 byte unchanged", v, 8'h7F);

    // R6 window status, R7 suspend/resume
    unlock_pgm(16'hC005, 8'h44);
    wait_idle();
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'hC000, 8'h30);
    rd(16'h0000, s1);
    chk(s1[3] == 1'b0 && s1[7] == 1'b0, "R6 window status", s1, 8'h00);
    repeat (WIN_CYC + 2) @(negedge clk);
    rd(16'h0000, s1);
    chk(s1[3] == 1'b1, "R6 erasing status", s1, 8'h08);
    wr(16'h0000, 8'hB0);
    chk(busy == 1'b0, "R7 suspend drops busy", {7'd0, busy}, 8'h00);
    rd(16'hC005, v);
    chk(v == 8'h44, "R7 array readable in suspend", v, 8'h44);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R7 suspend holds", {7'd0, busy}, 8'h00);
    wr(16'h0000, 8'h30);
    chk(busy == 1'b1, "R7 resume", {7'd0, busy}, 8'h01);
    wait_idle();
    rd(16'hC005, v);
    chk(v == 8'hFF, "R7 erase completes after resume", v, 8'hFF);

    // R12 unlocked reset leaves identifier mode
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h90);
    rd(16'h0000, v);
    chk(v == 8'h01, "R8 maker code", v, 8'h01);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hF0);
    rd(16'h0000, v);
    chk(v == 8'hFF, "R12 back to array", v, 8'hFF);

    // R7 suspend in read mode ignored
    wr(16'h0006, 8'hB0);
    chk(busy == 1'b0, "R7 stray suspend", {7'd0, busy}, 8'h00);
    rd(16'h0006, v);
    chk(v == 8'h00, "R7 stray suspend array", v, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule